// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous on-chip logic read and write an external asynchronous static RAM of 1M words by 16 bits. A client puts a request on a valid/ready handshake. The request carries a write flag, a word address, write data and a byte-lane mask. The controller then runs one complete memory cycle. It returns a single-cycle completion pulse, and for reads it returns the captured data with that pulse.

On the memory side the controller drives an active-low and an active-high chip select, a write strobe, an output enable and one active-low select per byte lane. It also drives the address and the outgoing data with a separate driver enable; the pad ring combines the outgoing data, the driver enable and the returned data into the shared three-state bus. All memory pins come from flip-flops.

Each phase of the memory cycle lasts a parameterised number of clock cycles: address setup, write pulse, write recovery, read access and bus turnaround. Each length is chosen as the ceiling of the nanosecond minimum divided by the clock period, so one RTL serves memories of different speed. Between transfers the memory is held in standby.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycles after it, the controller holds `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_bsel_n`=2'b11 and `mem_dq_oe`=0. It also holds `req_ready`=1 and `rsp_valid`=0.
- R2: Whenever no transfer is in progress, the memory is deselected (`mem_cs1_n`=1, `mem_cs2`=0) and both lane selects are high.
- R3: A write holds the address, lane selects and outgoing data stable for SETUP_CYC cycles with `mem_we_n` high. It then holds `mem_we_n` low for exactly WP_CYC cycles, and then holds it high for HOLD_CYC more cycles before the address or data may change.
- R4: `mem_dq_oe` is 1 only during the phases of a write, and it is never 1 while `mem_oe_n` is 0.
- R5: Mask bit 0 enables lane select `mem_bsel_n[0]`, which gates data bits 7:0. Mask bit 1 enables `mem_bsel_n[1]`, which gates bits 15:8. A write changes only the enabled bytes of the addressed word.
- R6: A read holds `mem_oe_n` low with `mem_we_n` high for RD_CYC cycles and captures the bus at the end of that window. The next cycle it pulses `rsp_valid` with the data on `rsp_rdata`.
- R7: In read data, the bytes whose mask bit is 0 return zero, whatever the bus carries on those lanes.
- R8: After a read, `req_ready` stays low and `mem_oe_n` stays high for TURN_CYC cycles before the next transfer can start.
- R9: A request is accepted only in a cycle where `req_ready` is 1. A request presented while `req_ready` is 0 has no effect. Each accepted request gives exactly one `rsp_valid` pulse, one cycle wide.
- R10: A write with mask 2'b00 completes its handshake and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 = low byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| mem_addr | output | 20 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_bsel_n | output | 2 | Lane selects, active low, bit 0 = bits 7:0 |
| mem_dq_o | output | 16 | Outgoing data to the pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_i | input | 16 | Data returned from the pad |

## Verification
The memory model on the bench returns a filler pattern until the access window has elapsed. It also returns filler on lanes it does not drive. A controller that samples one cycle early therefore returns wrong words, and one that forgets to mask idle lanes leaks the filler into `rsp_rdata`. The model times every write strobe: a pulse that is too short, or an address or data change during the pulse, is flagged. It also flags bus contention when both sides drive the bus, which catches a driver left on during output enable. Directed cases cover single-lane writes followed by full-word reads, a write with an empty mask, and a request raised while the controller is busy; a controller that latched the last of these would corrupt the target word.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WSET  = 3'd1,
    PH_WPUL  = 3'd2,
    PH_WREC  = 3'd3,
    PH_RACC  = 3'd4,
    PH_TURN  = 3'd5
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 5,
  parameter int TURN_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  input  logic [LANES-1:0] mask_q,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             done,
  output logic             cs1_n,
  output logic             cs2,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] bsel_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

  phase_e state_q, state_d;
  logic   done_d;

  logic             cs1_n_d, cs2_d, we_n_d, oe_n_d, dq_oe_d;
  logic [LANES-1:0] bsel_n_d;
  logic [LANES-1:0] mask_nx;
  logic             busy_nx;

  assign ready  = (state_q == PH_IDLE);
  assign accept = ready && req_valid;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = PH_WSET;
            tmr_val = SETUP_LD;
          end else begin
            state_d = PH_RACC;
            tmr_val = RD_LD;
          end
        end
      end
      PH_WSET: begin
        if (tmr_expired) begin
          state_d  = PH_WPUL;
          tmr_load = 1'b1;
          tmr_val  = WP_LD;
        end
      end
      PH_WPUL: begin
        if (tmr_expired) begin
          state_d  = PH_WREC;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      PH_WREC: begin
        if (tmr_expired) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end
      end
      PH_RACC: begin
        if (tmr_expired) begin
          state_d  = PH_TURN;
          capture  = 1'b1;
          done_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TURN_LD;
        end
      end
      PH_TURN: begin
        if (tmr_expired)
          state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  // pin decode from the next phase, so pins are flop outputs
  assign mask_nx = accept ? req_mask : mask_q;
  assign busy_nx = (state_d == PH_WSET) || (state_d == PH_WPUL) ||
                   (state_d == PH_WREC) || (state_d == PH_RACC);

  always_comb begin
    cs1_n_d  = !busy_nx;
    cs2_d    = busy_nx;
    we_n_d   = (state_d != PH_WPUL);
    oe_n_d   = (state_d != PH_RACC);
    dq_oe_d  = (state_d == PH_WSET) || (state_d == PH_WPUL) || (state_d == PH_WREC);
    bsel_n_d = ~(mask_nx & {LANES{busy_nx}});
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done    <= 1'b0;
      cs1_n   <= 1'b1;
      cs2     <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      bsel_n  <= '1;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      cs1_n   <= cs1_n_d;
      cs2     <= cs2_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
      bsel_n  <= bsel_n_d;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs1_n && !cs2 && (bsel_n == '1)));

  // R6
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !cs1_n && cs2));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_TURN) |-> (oe_n && !ready));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  mask_d;

  always_comb begin
    addr_d  = accept ? req_addr  : addr_q;
    wdata_d = accept ? req_wdata : wdata_q;
    mask_d  = accept ? req_mask  : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      mask_q  <= mask_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_d, lane_q;

    always_comb begin
      lane_d = lane_q;
      if (capture)
        lane_d = mask_q[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else
        lane_q <= lane_d;
    end

    assign rdata_q[g*LANE_W +: LANE_W] = lane_q;

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !mask_q[g]) |=> (lane_q == '0));
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 4,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 5,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W/8-1:0] mem_bsel_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int MAX_LEN = max2(max2(max2(SETUP_CYC, WP_CYC), max2(HOLD_CYC, RD_CYC)), TURN_CYC);
  localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             tmr_load, tmr_expired, accept, capture;
  logic [CNT_W-1:0] tmr_val;
  logic [LANES-1:0] mask_q;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .LANES(LANES), .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .WP_CYC(WP_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_mask    (req_mask),
    .mask_q      (mask_q),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .ready       (req_ready),
    .done        (rsp_valid),
    .cs1_n       (mem_cs1_n),
    .cs2         (mem_cs2),
    .we_n        (mem_we_n),
    .oe_n        (mem_oe_n),
    .bsel_n      (mem_bsel_n),
    .dq_oe       (mem_dq_oe)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .dq_i      (mem_dq_i),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_o),
    .mask_q    (mask_q),
    .rdata_q   (rsp_rdata)
  );

  // R4
  bus_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_dq_oe |-> mem_oe_n);

  // R3
  we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R3
  we_qualified_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_dq_oe && mem_oe_n));

  // R3
  we_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_cs1_n));

endmodule

// File: tb/test_sram_port_ctrl.sv
module test_sram_port_ctrl;

  localparam int CLK_NS   = 10;
  localparam int SETUP_C  = 1;
  localparam int WP_C     = 4;
  localparam int HOLD_C   = 1;
  localparam int RD_C     = 5;
  localparam int TURN_C   = 1;
  localparam int WP_MIN   = (35 + CLK_NS - 1) / CLK_NS;
  localparam int DS_MIN   = (25 + CLK_NS - 1) / CLK_NS;
  localparam int ACC_CYC  = (45 + CLK_NS - 1) / CLK_NS;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bsel_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  sram_port_ctrl #(
    .SETUP_CYC(SETUP_C), .WP_CYC(WP_C), .HOLD_CYC(HOLD_C),
    .RD_CYC(RD_C), .TURN_CYC(TURN_C)
  ) i_sram_port_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_bsel_n(mem_bsel_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  int n_acc = 0;
  int n_done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // ---------------- memory model ----------------
  logic [15:0] mm [int];
  logic [15:0] sb [int];

  function automatic logic [15:0] init_word(input logic [19:0] a);
    return a[15:0] ^ 16'h3C3C;
  endfunction

  function automatic logic [15:0] mm_get(input logic [19:0] a);
    if (mm.exists(int'(a))) return mm[int'(a)];
    return init_word(a);
  endfunction

  function automatic logic [15:0] sb_get(input logic [19:0] a);
    if (sb.exists(int'(a))) return sb[int'(a)];
    return init_word(a);
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  logic [15:0] model_dq = 16'h5A5A;
  int          acc_cnt = 0;
  bit          wr_prev = 0;
  int          pulse = 0;
  int          last_pulse = 0;
  logic [19:0] w_addr;
  logic [15:0] w_data;
  logic [1:0]  w_bsel;

  assign mem_dq_i = model_dq;

  always @(negedge clk) begin
    bit sel, rd_on, wr_on;
    logic [1:0]  drv;
    logic [15:0] word, tmp;
    sel   = !mem_cs1_n && mem_cs2;
    rd_on = sel && mem_we_n && !mem_oe_n;
    wr_on = sel && !mem_we_n && (mem_bsel_n != 2'b11);
    acc_cnt = rd_on ? acc_cnt + 1 : 0;
    drv  = rd_on ? ~mem_bsel_n : 2'b00;
    word = (acc_cnt >= ACC_CYC) ? mm_get(mem_addr) : 16'hA5A5;
    model_dq = {drv[1] ? word[15:8] : 8'h5A, drv[0] ? word[7:0] : 8'h5A};
    // R4 contention
    if (mem_dq_oe && drv != 2'b00)
      chk(0, "R4 contention", {31'd0, mem_dq_oe}, 32'd0);
    if (wr_on) begin
      if (!wr_prev) begin
        pulse = 1; w_addr = mem_addr; w_data = mem_dq_o; w_bsel = mem_bsel_n;
      end else begin
        pulse++;
        if (mem_addr != w_addr || mem_dq_o != w_data || mem_bsel_n != w_bsel || !mem_dq_oe)
          chk(0, "R3 signal moved during write pulse", {12'd0, mem_addr}, {12'd0, w_addr});
      end
    end else if (wr_prev) begin
      last_pulse = pulse;
      if (pulse < WP_MIN || pulse < DS_MIN)
        chk(0, "R3 write pulse too short", pulse, WP_MIN);
      tmp = mm_get(w_addr);
      if (!w_bsel[0]) tmp[7:0]  = w_data[7:0];
      if (!w_bsel[1]) tmp[15:8] = w_data[15:8];
      mm[int'(w_addr)] = tmp;
    end
    wr_prev = wr_on;
  end

  always @(posedge clk) if (rst_n && rsp_valid) n_done++;

  // ---------------- transfer task ----------------
  task automatic xfer(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] e, t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    n_acc++;
    while (!rsp_valid) @(negedge clk);
    // R2: memory deselected once the cycle has finished
    chk(mem_cs1_n && !mem_cs2 && mem_bsel_n == 2'b11, "R2 standby after transfer",
        {mem_cs1_n, mem_cs2, mem_bsel_n}, 4'b1011);
    if (w) begin
      t = sb_get(a);
      if (m[0]) t[7:0]  = d[7:0];
      if (m[1]) t[15:8] = d[15:8];
      sb[int'(a)] = t;
      if (m != 2'b00) chk(last_pulse == WP_C, "R3 write pulse length", last_pulse, WP_C);
    end else begin
      e = exp_read(sb_get(a), m);
      if (m == 2'b11) chk(rsp_rdata == e, "R6 read data", rsp_rdata, e);
      else            chk(rsp_rdata == e, "R7 masked read data", rsp_rdata, e);
      chk(!req_ready && mem_oe_n, "R8 turnaround after read", {req_ready, mem_oe_n}, 2'b01);
    end
    @(negedge clk);
    chk(!rsp_valid, "R9 done pulse width", rsp_valid, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [19:0] a;
    int dummy;
    dummy = $urandom(32'h5EED);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && mem_bsel_n == 2'b11 && !mem_dq_oe,
        "R1 memory pins in reset",
        {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_bsel_n, mem_dq_oe}, 7'b1011110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 handshake after reset", {req_ready, rsp_valid}, 2'b10);
    chk(mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R1 pins after reset",
        {mem_cs1_n, mem_cs2, mem_dq_oe}, 3'b100);

    // directed: full word, then each lane alone (R5)
    xfer(1, 20'h00010, 16'hBEEF, 2'b11);
    xfer(0, 20'h00010, 16'h0000, 2'b11);
    xfer(1, 20'h00010, 16'h1122, 2'b01);
    xfer(0, 20'h00010, 16'h0000, 2'b11);
    chk(rsp_rdata == 16'hBE22, "R5 low-lane write", rsp_rdata, 16'hBE22);
    xfer(1, 20'h00010, 16'h3344, 2'b10);
    xfer(0, 20'h00010, 16'h0000, 2'b11);
    chk(rsp_rdata == 16'h3322, "R5 high-lane write", rsp_rdata, 16'h3322);
    // R7 single-lane reads
    xfer(0, 20'h00010, 16'h0000, 2'b01);
    xfer(0, 20'h00010, 16'h0000, 2'b10);
    xfer(0, 20'h00010, 16'h0000, 2'b00);
    // R10 empty-mask write leaves word intact
    xfer(1, 20'h00010, 16'hFFFF, 2'b00);
    xfer(0, 20'h00010, 16'h0000, 2'b11);
    chk(rsp_rdata == 16'h3322, "R10 empty-mask write", rsp_rdata, 16'h3322);
    // address extremes
    xfer(1, 20'hFFFFF, 16'hCAFE, 2'b11);
    xfer(1, 20'h00000, 16'h0F0F, 2'b11);
    xfer(0, 20'hFFFFF, 16'h0000, 2'b11);
    xfer(0, 20'h00000, 16'h0000, 2'b11);

    // R9 request while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00020; req_mask = 2'b11;
    @(negedge clk);
    n_acc++;
    req_write = 1'b1; req_addr = 20'h00030; req_wdata = 16'hDEAD; req_mask = 2'b11;
    chk(!req_ready, "R9 busy after accept", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == sb_get(20'h00020), "R6 read before busy poke", rsp_rdata, sb_get(20'h00020));
    xfer(0, 20'h00030, 16'h0000, 2'b11);
    chk(rsp_rdata == init_word(20'h00030), "R9 busy request ignored", rsp_rdata, init_word(20'h00030));

    // random mix
    for (int i = 0; i < 400; i++) begin
      a = ($urandom % 4 == 0) ? 20'($urandom) : {12'hA5C, 8'($urandom % 24)};
      xfer(($urandom % 2) == 1, a, 16'($urandom), 2'($urandom));
    end

    repeat (4) @(negedge clk);
    chk(n_done == n_acc, "R9 one completion per request", n_done, n_acc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule